// File: doc/BRIEF.md
# Missing-Gate Test Vector Generator for Reversible Cascades

The block takes the description of a cascade of multi-control Toffoli gates and produces a compact set of input vectors that expose every single missing-gate fault in it. For each gate in turn, it takes a pattern with every line at logic one at the output of that gate. It then walks backwards through that gate and all gates before it, using the fact that every such gate is its own inverse. The result is a candidate primary-input vector. Under that vector, the control lines of the chosen gate are all one when the gate is reached.

Each candidate is fault-simulated on a bank of parallel lanes. One lane is fault-free, and each other lane has one gate removed. The lanes are compared with the fault-free output. Faults that the candidate exposes are dropped from a pending mask. A candidate is offered on a valid/ready output stream only if it drops at least one fault that was still pending. The run ends when the mask is empty or the last gate has been tried. The number of vectors sent and the remaining mask then stay visible until the next start.

The circuit description is read from plain input pins. It must be held stable from start until done. Back-pressure follows the usual rule: while `vec_valid` is high and `vec_ready` is low, the beat is held unchanged. A beat moves on each rising edge where both signals are high. The generator does not advance while it is waiting on the stream.

Top module: `mgf_testgen`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy`, `done` and `vec_valid` are low and `vec_count` is zero.
- R2: Bit l of a vector is line l. Gate g takes its control mask from `gate_ctrl[g*LINES +: LINES]` and its target line index from `gate_tgt[g*TW +: TW]`. The gate flips the target bit when every masked control line is one. A control bit set on the gate's own target line is ignored, and an empty mask makes the gate a plain inverter.
- R3: The candidate for gate i is the all-ones vector propagated backwards through gates i, i-1, …, 0.
- R4: Candidates are tried in gate order 0 upward. A candidate is sent only if at least one still-pending gate k exists whose removal changes the cascade output for that candidate. Vectors leave in the order they are found.
- R5: Every fault a candidate exposes is removed from the pending mask and is not tested again. The run stops once the mask is empty, so at most GATES vectors are sent. `vec_count` equals the number of beats accepted.
- R6: While `vec_valid` is high and `vec_ready` is low, `vec_valid` stays high and `vec_data` does not change.
- R7: The first `vec_valid` of a run rises on the (GATES+3)-th rising edge, counting the edge that samples `start` as the first.
- R8: At the end of a run, `done` is high, `busy` is low, and `vec_count` and `left_mask` hold their final values until the next accepted start. For any description obeying R2, `left_mask` ends at zero.
- R9: A `start` pulse while `busy` is high has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| gate_ctrl | input | GATES*LINES | Control masks, one LINES-bit field per gate |
| gate_tgt | input | GATES*TW | Target line index, one TW-bit field per gate |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| vec_valid | output | 1 | Stream beat available |
| vec_ready | input | 1 | Consumer accepts the beat |
| vec_data | output | LINES | Test vector, bit l drives line l |
| vec_count | output | CW | Number of vectors accepted in this run |
| left_mask | output | GATES | Faults still pending; bit g is gate g |

## Verification
Candidate i takes i+1 backward cycles, GATES simulation cycles, a compare cycle and, when it is sent, one or more stream cycles. As a result, only the first beat has a fixed latency of GATES+3 edges. The bench counts edges from the start edge and checks that this first rise happens exactly there. Later beats are checked by handshake order against a software cascade model rather than by cycle. Stalled beats are compared on the following falling edge. Count, mask and busy are read once `done` is seen, since they are registered in the cycle the generator leaves its last state.

// File: rtl/mgf_testgen_pkg.sv
package mgf_testgen_pkg;

  typedef enum logic [2:0] {
    TG_IDLE,
    TG_BACK,
    TG_SIM,
    TG_CMP,
    TG_EMIT,
    TG_ADV,
    TG_DONE
  } tg_state_e;

endpackage

// File: rtl/mgf_gate_apply.sv
module mgf_gate_apply #(
  parameter int LINES = 4,
  parameter int TW    = 2
) (
  input  logic [LINES-1:0] vec_i,
  input  logic [LINES-1:0] ctrl_i,
  input  logic [TW-1:0]    tgt_i,
  input  logic             en_i,
  output logic [LINES-1:0] vec_o
);

  logic [LINES-1:0] tmask;
  logic [LINES-1:0] ctrl_eff;
  logic             fire;

  for (genvar l = 0; l < LINES; l++) begin : g_tdec
    assign tmask[l] = (tgt_i == TW'(l));
  end

  assign ctrl_eff = ctrl_i & ~tmask;
  assign fire     = en_i && (&(vec_i | ~ctrl_eff));
  assign vec_o    = fire ? (vec_i ^ tmask) : vec_i;

endmodule

// File: rtl/mgf_backprop.sv
module mgf_backprop #(
  parameter int LINES = 4,
  parameter int TW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LINES-1:0] ctrl_i,
  input  logic [TW-1:0]    tgt_i,
  output logic [LINES-1:0] vec_o,
  output logic [LINES-1:0] next_o
);

  logic [LINES-1:0] vec_q;

  mgf_gate_apply #(.LINES(LINES), .TW(TW)) u_inv (
    .vec_i (vec_q),
    .ctrl_i(ctrl_i),
    .tgt_i (tgt_i),
    .en_i  (1'b1),
    .vec_o (next_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '1;
    else if (load_i) vec_q <= '1;
    else if (step_i) vec_q <= next_o;
  end

  assign vec_o = vec_q;

  // R3
  reload_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> vec_q == '1);

endmodule

// File: rtl/mgf_lane_bank.sv
module mgf_lane_bank #(
  parameter int LINES = 4,
  parameter int GATES = 4,
  parameter int TW    = 2,
  parameter int GW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LINES-1:0] load_vec_i,
  input  logic             step_i,
  input  logic [GW-1:0]    gidx_i,
  input  logic [LINES-1:0] ctrl_i,
  input  logic [TW-1:0]    tgt_i,
  output logic [GATES-1:0] det_o
);

  localparam int NLANE = GATES + 1;

  logic [LINES-1:0] lane_q [NLANE];
  logic [LINES-1:0] lane_d [NLANE];
  logic [NLANE-1:0] lane_en;

  assign lane_en[0] = 1'b1;
  for (genvar j = 0; j < GATES; j++) begin : g_skip
    assign lane_en[j+1] = (gidx_i != GW'(j));
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    mgf_gate_apply #(.LINES(LINES), .TW(TW)) u_fwd (
      .vec_i (lane_q[k]),
      .ctrl_i(ctrl_i),
      .tgt_i (tgt_i),
      .en_i  (lane_en[k]),
      .vec_o (lane_d[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)      lane_q[k] <= '0;
      else if (load_i) lane_q[k] <= load_vec_i;
      else if (step_i) lane_q[k] <= lane_d[k];
    end
  end

  for (genvar j = 0; j < GATES; j++) begin : g_det
    assign det_o[j] = (lane_q[j+1] != lane_q[0]);
  end

  // R4
  lanes_agree_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> det_o == '0);

endmodule

// File: rtl/mgf_testgen.sv
module mgf_testgen
  import mgf_testgen_pkg::*;
#(
  parameter int LINES = 4,
  parameter int GATES = 4,
  localparam int TW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW = $clog2(GATES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [GATES*LINES-1:0] gate_ctrl,
  input  logic [GATES*TW-1:0]    gate_tgt,
  output logic                   busy,
  output logic                   done,
  output logic                   vec_valid,
  input  logic                   vec_ready,
  output logic [LINES-1:0]       vec_data,
  output logic [CW-1:0]          vec_count,
  output logic [GATES-1:0]       left_mask
);

  localparam int GW = (GATES > 1) ? $clog2(GATES) : 1;
  localparam logic [GW-1:0] LAST_G = GW'(GATES - 1);

  tg_state_e        state_q;
  logic [GW-1:0]    cand_q, bstep_q, sstep_q;
  logic [GATES-1:0] pend_q;
  logic [CW-1:0]    cnt_q;

  logic             start_ok, last_adv;
  logic             bp_load, bp_step, ln_load, ln_step;
  logic [LINES-1:0] bp_vec, bp_next;
  logic [LINES-1:0] ctrl_b, ctrl_s;
  logic [TW-1:0]    tgt_b, tgt_s;
  logic [GATES-1:0] det, fresh;

  assign start_ok = start && (state_q == TG_IDLE || state_q == TG_DONE);
  assign last_adv = (pend_q == '0) || (cand_q == LAST_G);

  assign ctrl_b = gate_ctrl[int'(bstep_q)*LINES +: LINES];
  assign tgt_b  = gate_tgt[int'(bstep_q)*TW +: TW];
  assign ctrl_s = gate_ctrl[int'(sstep_q)*LINES +: LINES];
  assign tgt_s  = gate_tgt[int'(sstep_q)*TW +: TW];

  assign bp_load = start_ok || (state_q == TG_ADV && !last_adv);
  assign bp_step = (state_q == TG_BACK);
  assign ln_load = (state_q == TG_BACK) && (bstep_q == '0);
  assign ln_step = (state_q == TG_SIM);

  mgf_backprop #(.LINES(LINES), .TW(TW)) u_back (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(bp_load),
    .step_i(bp_step),
    .ctrl_i(ctrl_b),
    .tgt_i (tgt_b),
    .vec_o (bp_vec),
    .next_o(bp_next)
  );

  mgf_lane_bank #(.LINES(LINES), .GATES(GATES), .TW(TW), .GW(GW)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ln_load),
    .load_vec_i(bp_next),
    .step_i    (ln_step),
    .gidx_i    (sstep_q),
    .ctrl_i    (ctrl_s),
    .tgt_i     (tgt_s),
    .det_o     (det)
  );

  assign fresh = pend_q & det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TG_IDLE;
      cand_q  <= '0;
      bstep_q <= '0;
      sstep_q <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        TG_IDLE, TG_DONE: begin
          if (start_ok) begin
            state_q <= TG_BACK;
            cand_q  <= '0;
            bstep_q <= '0;
            pend_q  <= '1;
            cnt_q   <= '0;
          end
        end
        TG_BACK: begin
          if (bstep_q == '0) begin
            state_q <= TG_SIM;
            sstep_q <= '0;
          end else begin
            bstep_q <= bstep_q - GW'(1);
          end
        end
        TG_SIM: begin
          if (sstep_q == LAST_G) state_q <= TG_CMP;
          else                   sstep_q <= sstep_q + GW'(1);
        end
        TG_CMP: begin
          pend_q  <= pend_q & ~det;
          state_q <= (fresh != '0) ? TG_EMIT : TG_ADV;
        end
        TG_EMIT: begin
          if (vec_ready) begin
            cnt_q   <= cnt_q + CW'(1);
            state_q <= TG_ADV;
          end
        end
        TG_ADV: begin
          if (last_adv) begin
            state_q <= TG_DONE;
          end else begin
            state_q <= TG_BACK;
            cand_q  <= cand_q + GW'(1);
            bstep_q <= cand_q + GW'(1);
          end
        end
        default: state_q <= TG_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != TG_IDLE) && (state_q != TG_DONE);
  assign done      = (state_q == TG_DONE);
  assign vec_valid = (state_q == TG_EMIT);
  assign vec_data  = bp_vec;
  assign vec_count = cnt_q;
  assign left_mask = pend_q;

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data));

  // R5
  count_tracks_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(vec_valid && vec_ready) || $past(start_ok)));

  // R5
  pending_only_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |-> $past(start_ok));

  // R4
  beat_drops_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> pend_q != $past(pend_q));

  // R8
  full_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> left_mask == '0 && !busy);

endmodule

// File: tb/mgf_testgen_bench.sv
module mgf_testgen_bench;

  localparam int NL = 4;
  localparam int NG = 4;
  localparam int TW = 2;
  localparam int CW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NG*NL-1:0]  gate_ctrl = '0;
  logic [NG*TW-1:0]  gate_tgt = '0;
  logic              busy, done, vec_valid;
  logic              vec_ready = 1'b0;
  logic [NL-1:0]     vec_data;
  logic [CW-1:0]     vec_count;
  logic [NG-1:0]     left_mask;

  always #4 clk = ~clk;

  mgf_testgen #(.LINES(NL), .GATES(NG)) u_mgf_testgen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .gate_ctrl(gate_ctrl), .gate_tgt(gate_tgt),
    .busy(busy), .done(done),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .vec_count(vec_count), .left_mask(left_mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] rs = 32'h1F2E3D4C;

  logic [NL-1:0] exp_v [NG];
  int            exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // gate model from R2, arithmetic form
  function automatic logic [NL-1:0] gapply(input logic [NL-1:0] v,
      input logic [NG*NL-1:0] c, input logic [NG*TW-1:0] t, input int g);
    int tl = int'(t[g*TW +: TW]);
    logic [NL-1:0] cm = c[g*NL +: NL];
    cm[tl] = 1'b0;
    if ((v & cm) == cm) v[tl] = ~v[tl];
    return v;
  endfunction

  function automatic logic [NL-1:0] run_cas(input logic [NL-1:0] v,
      input logic [NG*NL-1:0] c, input logic [NG*TW-1:0] t, input int skip);
    for (int g = 0; g < NG; g++) if (g != skip) v = gapply(v, c, t, g);
    return v;
  endfunction

  task automatic build_ref(input logic [NG*NL-1:0] c, input logic [NG*TW-1:0] t);
    logic [NG-1:0] pend = '1;
    exp_n = 0;
    for (int i = 0; i < NG && pend != '0; i++) begin
      logic [NL-1:0] tv = '1;
      logic [NL-1:0] good;
      logic [NG-1:0] det;
      for (int g = i; g >= 0; g--) tv = gapply(tv, c, t, g);
      good = run_cas(tv, c, t, -1);
      for (int j = 0; j < NG; j++) det[j] = (run_cas(tv, c, t, j) != good);
      if ((det & pend) != '0) begin
        exp_v[exp_n] = tv;
        exp_n++;
      end
      pend = pend & ~det;
    end
  endtask

  task automatic run_circuit(input logic [NG*NL-1:0] c, input logic [NG*TW-1:0] t,
                             input bit poke);
    int got = 0;
    int first = -1;
    bit stall = 1'b0;
    logic [NL-1:0] held = '0;
    bit fin = 1'b0;
    build_ref(c, t);
    gate_ctrl = c;
    gate_tgt  = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < 600; k++) begin
      rs = nxt(rs);
      vec_ready = rs[3] | rs[9];
      start = poke && (k == 3);   // R9: ignored while busy
      if (stall)  // R6
        chk(vec_valid && vec_data == held, "R6", "stalled beat changed",
            int'(vec_data), int'(held));
      if (vec_valid && first < 0) first = k;
      stall = vec_valid && !vec_ready;
      held  = vec_data;
      if (vec_valid && vec_ready) begin
        if (got < exp_n)  // R3 R4
          chk(vec_data == exp_v[got], "R4", "vector value/order",
              int'(vec_data), int'(exp_v[got]));
        else
          chk(1'b0, "R5", "beat beyond expected count", got + 1, exp_n);
        got++;
      end
      if (done) begin
        fin = 1'b1;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    vec_ready = 1'b0;
    if (!fin) chk(1'b0, "R8", "run timed out", 0, 1);
    else begin
      chk(got == exp_n, "R4", "beats sent", got, exp_n);
      chk(int'(vec_count) == exp_n, "R5", "vec_count", int'(vec_count), exp_n);
      chk(left_mask == '0, "R8", "left_mask", int'(left_mask), 0);
      chk(!busy, "R8", "busy at done", int'(busy), 0);
      chk(first == NG + 3, "R7", "first valid edge", first, NG + 3);
    end
    @(negedge clk);
    chk(done && int'(vec_count) == exp_n, "R8", "results held after done",
        int'(vec_count), exp_n);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !vec_valid && vec_count == '0, "R1", "state in reset",
        int'({busy, done, vec_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !vec_valid && vec_count == '0, "R1", "idle after reset",
        int'({busy, done, vec_valid}), 0);

    // R3 R5: four inverters on distinct lines; first candidate covers all
    build_ref('0, {2'd3, 2'd2, 2'd1, 2'd0});
    chk(exp_n == 1 && exp_v[0] == 4'b1110, "R3", "reference inverter case",
        int'(exp_v[0]), 14);
    run_circuit('0, {2'd3, 2'd2, 2'd1, 2'd0}, 1'b0);

    // R2: every gate's mask also names its own target line
    run_circuit(16'hFFFF, {2'd0, 2'd1, 2'd2, 2'd3}, 1'b1);

    // sweep of gate 0 exhaustively with fixed tail, then pseudo-random circuits
    for (int s = 0; s < 64; s++)
      run_circuit({12'h9C3, 4'(s)}, {2'd2, 2'd0, 2'd3, 2'(s >> 4)}, s[0]);
    for (int n = 0; n < 200; n++) begin
      rs = nxt(rs);
      run_circuit(rs[15:0], rs[23:16], n[0]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule